// File: doc/BRIEF.md
# Stop-Mode Wake-Up Controller

This block parks a small processor core in a low-power stop state and decides when it may run again. While the core runs, a stop request moves the block into stop, where both the core clock enable and the run enable fall. A control register then names one wake condition: a single port pin, a NOR over the low nibble of the eight-bit port, or a NOR over all eight bits of it. The register also sets the level that counts as active and whether a stabilisation wait is inserted before execution resumes.

All pin inputs cross a two-flop synchroniser. The selected condition must hold for a run of consecutive sampled cycles before a wake is accepted, so a short glitch leaves the core asleep. When a wake is accepted, the clock enable rises at once. The run enable rises either in the same cycle or after a parameterised stabilisation count. A status bit that software can only read tells a warm start, meaning a recovery from stop, apart from a cold start caused by power-on or external reset.

Eight-bit port bits that the core drives as outputs take no part in a NOR term. Their inputs are treated as 0, so only the bits configured as inputs decide the result.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After power-on or external reset, rd_data reads 6'b001000: select 000, delay enable 1, wake-high 0, warm flag 0. Both run_en and clk_en are 1.
- R2: When wr_en is set, the next edge loads wr_data[2:0] into the select field, wr_data[3] into delay enable and wr_data[4] into wake-high. wr_data[5] is ignored. rd_data shows {warm flag, wake-high, delay enable, select} at bits 5, 4, 3 and 2:0.
- R3: A stop_req high at an edge while the block runs clears clk_en and run_en after that edge. A stop_req seen in any other state has no effect.
- R4: Select codes for single pins: 010 = p3_in[0], 011 = p3_in[1], 100 = p3_in[2], 101 = p2_in[7]. No other pin affects these codes.
- R5: With select 000 or 001, no pin state wakes the block. Only reset returns it to running.
- R6: Select 110 uses the NOR of p2_in[3:0] and select 111 uses the NOR of p2_in[7:0]. A bit whose p2_dir_out is 1 counts as 0 in the NOR.
- R7: With wake-high = 1, a high level on the selected source is active. With wake-high = 0, a low level is active.
- R8: A wake is accepted only after the synchronised source has been active for QUAL_CYC (default 5) consecutive edges. A pin that turns active just before edge A is accepted at edge A+6. An active run shorter than that leaves the block stopped.
- R9: With delay enable = 0, clk_en and run_en both rise at the accepting edge. With delay enable = 1, clk_en rises at that edge and run_en rises DELAY_CYC edges later.
- R10: The warm flag is set when the block returns to running after a stop. Power-on or external reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| p2_in | input | 8 | Eight-bit port pin levels |
| p2_dir_out | input | 8 | Per-bit flag: 1 = bit is driven as an output |
| p3_in | input | 3 | Pins 1 to 3 of the second port (bit 0 = pin 1) |
| stop_req | input | 1 | Request to enter stop |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 6 | Control register write data |
| rd_data | output | 6 | Control register and warm flag read value |
| clk_en | output | 1 | Core clock enable / wake |
| run_en | output | 1 | Core may execute |

## Verification
A sequencer stuck in the wrong state shows up at clk_en and run_en within one edge of the next stop request or wake. The check waits for the edge at which each enable must change and samples one cycle on either side of it, so an error of a single cycle in the synchroniser or the qualification count is caught at once. A wrong source decode or a wrong output-bit mask leaves the enables low past the expected wake edge. A wrong polarity wakes the core early, and that shows in the first sample after stop. A stale or miswritten register field appears in rd_data one edge after the write.

// File: rtl/swk_pkg.sv
package swk_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_QUAL = 2'd2,
    ST_DLY  = 2'd3
  } swk_state_e;

  localparam logic [2:0] SEL_NONE    = 3'd0;
  localparam logic [2:0] SEL_RSVD    = 3'd1;
  localparam logic [2:0] SEL_P3_PIN1 = 3'd2;
  localparam logic [2:0] SEL_P3_PIN2 = 3'd3;
  localparam logic [2:0] SEL_P3_PIN3 = 3'd4;
  localparam logic [2:0] SEL_P2_PIN7 = 3'd5;
  localparam logic [2:0] SEL_NOR_LO  = 3'd6;
  localparam logic [2:0] SEL_NOR_ALL = 3'd7;

  // NOR over the port bits that are inputs; output bits count as 0
  function automatic logic port_nor(input logic [7:0] pins,
                                    input logic [7:0] drv_out,
                                    input logic       wide);
    logic [7:0] live;
    live = pins & ~drv_out;
    if (!wide) live[7:4] = 4'b0000;
    return ~|live;
  endfunction

  // level to "active" under the chosen polarity
  function automatic logic level_active(input logic lvl, input logic wake_high);
    return wake_high ? lvl : ~lvl;
  endfunction

  // true when a counter has reached the last value of a run of 'len' cycles
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/swk_src_sel.sv
module swk_src_sel
  import swk_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       wake_high,
  input  logic [7:0] p2_s,
  input  logic [7:0] p2_dir_out,
  input  logic [2:0] p3_s,
  output logic       src_act
);
  logic lvl;
  logic valid;

  always_comb begin
    lvl   = 1'b0;
    valid = 1'b1;
    case (sel)
      SEL_P3_PIN1: lvl = p3_s[0];
      SEL_P3_PIN2: lvl = p3_s[1];
      SEL_P3_PIN3: lvl = p3_s[2];
      SEL_P2_PIN7: lvl = p2_s[7] & ~p2_dir_out[7];
      SEL_NOR_LO:  lvl = port_nor(p2_s, p2_dir_out, 1'b0);
      SEL_NOR_ALL: lvl = port_nor(p2_s, p2_dir_out, 1'b1);
      default:     valid = 1'b0;   // SEL_NONE and SEL_RSVD
    endcase
  end

  assign src_act = valid & level_active(lvl, wake_high);
endmodule

// File: rtl/swk_seq.sv
module swk_seq
  import swk_pkg::*;
#(
  parameter int QUAL_CYC  = 5,
  parameter int DELAY_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic src_act,
  input  logic delay_en,
  output logic clk_en,
  output logic run_en,
  output logic wake_done
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int DW = $clog2(DELAY_CYC + 1);

  swk_state_e    st_q, st_d;
  logic [QW-1:0] q_cnt, q_d;
  logic [DW-1:0] d_cnt, d_d;
  logic          qual_last, dly_last;

  assign qual_last = at_last(32'(q_cnt), QUAL_CYC);
  assign dly_last  = at_last(32'(d_cnt), DELAY_CYC);

  always_comb begin
    st_d = st_q;
    q_d  = q_cnt;
    d_d  = d_cnt;
    case (st_q)
      ST_RUN:  if (stop_req) st_d = ST_STOP;
      ST_STOP: if (src_act) begin
        st_d = ST_QUAL;
        q_d  = QW'(1);
      end
      ST_QUAL: begin
        if (!src_act) st_d = ST_STOP;
        else if (qual_last) begin
          st_d = delay_en ? ST_DLY : ST_RUN;
          d_d  = '0;
        end else q_d = q_cnt + QW'(1);
      end
      ST_DLY: begin
        if (dly_last) st_d = ST_RUN;
        else          d_d  = d_cnt + DW'(1);
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      q_cnt <= '0;
      d_cnt <= '0;
    end else begin
      st_q  <= st_d;
      q_cnt <= q_d;
      d_cnt <= d_d;
    end
  end

  assign wake_done = (st_q != ST_RUN) && (st_d == ST_RUN);
  assign clk_en    = (st_q == ST_RUN) || (st_q == ST_DLY);
  assign run_en    = (st_q == ST_RUN);

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !stop_req) |=> st_q == ST_RUN); // R3

  AST_QUAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_QUAL && !src_act) |=> st_q == ST_STOP); // R8

  AST_WAKE_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(st_q) == ST_QUAL); // R8

  AST_DLY_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_DLY |-> d_cnt < DW'(DELAY_CYC)); // R9
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 5,
  parameter int DELAY_CYC   = 256
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic [7:0] p2_in,
  input  logic [7:0] p2_dir_out,
  input  logic [2:0] p3_in,
  input  logic       stop_req,
  input  logic       wr_en,
  input  logic [5:0] wr_data,
  output logic [5:0] rd_data,
  output logic       clk_en,
  output logic       run_en
);
  localparam int PIN_W = 8 + 3;

  logic             rst_n;
  logic [PIN_W-1:0] pins_s;
  logic [2:0]       sel_q;
  logic             dly_en_q, wake_high_q, warm_q;
  logic             src_act, wake_done;
  logic             unused_wr_bit;

  assign rst_n         = por_n & ext_rst_n;
  assign unused_wr_bit = wr_data[5];

  swk_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({p3_in, p2_in}),
    .q     (pins_s)
  );

  swk_src_sel u_sel (
    .sel        (sel_q),
    .wake_high  (wake_high_q),
    .p2_s       (pins_s[7:0]),
    .p2_dir_out (p2_dir_out),
    .p3_s       (pins_s[10:8]),
    .src_act    (src_act)
  );

  swk_seq #(.QUAL_CYC(QUAL_CYC), .DELAY_CYC(DELAY_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .src_act   (src_act),
    .delay_en  (dly_en_q),
    .clk_en    (clk_en),
    .run_en    (run_en),
    .wake_done (wake_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= SEL_NONE;
      dly_en_q    <= 1'b1;
      wake_high_q <= 1'b0;
    end else if (wr_en) begin
      sel_q       <= wr_data[2:0];
      dly_en_q    <= wr_data[3];
      wake_high_q <= wr_data[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         warm_q <= 1'b0;
    else if (wake_done) warm_q <= 1'b1;
  end

  assign rd_data = {warm_q, wake_high_q, dly_en_q, sel_q};

  AST_NO_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SEL_NONE || sel_q == SEL_RSVD) |-> !src_act); // R5

  AST_FLAG_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> warm_q); // R10

  AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stop_req) |=> !clk_en && !run_en); // R3
endmodule

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;
  localparam int DLY = 256;

  logic       clk = 1'b0;
  logic       por_n, ext_rst_n;
  logic [7:0] p2_in, p2_dir_out;
  logic [2:0] p3_in;
  logic       stop_req, wr_en;
  logic [5:0] wr_data;
  logic [5:0] rd_data;
  logic       clk_en, run_en;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  stop_wake_ctrl #(.QUAL_CYC(5), .DELAY_CYC(DLY)) uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .p2_in(p2_in), .p2_dir_out(p2_dir_out), .p3_in(p3_in),
    .stop_req(stop_req), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_en(clk_en), .run_en(run_en)
  );

  typedef struct {
    string      req;
    logic       run;
    logic       ck;
    logic [5:0] rd;
  } exp_t;

  exp_t sb[$];

  // expectation for the outputs just after the coming rising edge
  task automatic expect_next(string req, logic run, logic ck, logic [5:0] rd);
    exp_t e;
    e.req = req; e.run = run; e.ck = ck; e.rd = rd;
    sb.push_back(e);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(logic [5:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_stop(logic [5:0] rd);
    stop_req = 1'b1;
    expect_next("R3", 1'b0, 1'b0, rd);
    step();
    stop_req = 1'b0;
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (run_en !== e.run || clk_en !== e.ck || rd_data !== e.rd) begin
          n_bad++;
          $display("FAIL %s: run_en=%b clk_en=%b rd_data=%b expected run_en=%b clk_en=%b rd_data=%b",
                   e.req, run_en, clk_en, rd_data, e.run, e.ck, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected finish before timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1;
    p2_in = 8'h00; p2_dir_out = 8'h00; p3_in = 3'b000;
    stop_req = 1'b0; wr_en = 1'b0; wr_data = '0;
    step(2);
    expect_next("R1", 1'b1, 1'b1, 6'b001000);
    step();
    por_n = 1'b1;
    step();
    expect_next("R1", 1'b1, 1'b1, 6'b001000);
    step();

    // R2: select 010, fast, wake-high; bit 5 must not reach the flag
    write_reg(6'b110010);
    expect_next("R2", 1'b1, 1'b1, 6'b010010);
    step();

    // R4/R8: pin1 of p3 wakes at A+6, fast mode
    do_stop(6'b010010);
    p3_in = 3'b001;
    step(5);
    expect_next("R8", 1'b0, 1'b0, 6'b010010);
    step();
    expect_next("R10", 1'b1, 1'b1, 6'b110010);
    step();
    p3_in = 3'b000;
    step(3);

    // R5: codes 000 and 001 never wake
    write_reg(6'b000000);
    do_stop(6'b100000);
    p2_in = 8'hFF; p3_in = 3'b000;
    step(20);
    expect_next("R5", 1'b0, 1'b0, 6'b100000);
    step();
    p2_in = 8'h00; p3_in = 3'b111;
    step(20);
    expect_next("R5", 1'b0, 1'b0, 6'b100000);
    step();
    write_reg(6'b010001);
    p3_in = 3'b000;
    step(20);
    expect_next("R5", 1'b0, 1'b0, 6'b110001);
    step();
    ext_rst_n = 1'b0;
    expect_next("R10", 1'b1, 1'b1, 6'b001000);
    step();
    ext_rst_n = 1'b1;
    step();
    expect_next("R1", 1'b1, 1'b1, 6'b001000);
    step();

    // R8: four active cycles are not enough; five are
    write_reg(6'b010100);
    do_stop(6'b010100);
    p3_in = 3'b100;
    step(4);
    p3_in = 3'b000;
    step(15);
    expect_next("R8", 1'b0, 1'b0, 6'b010100);
    step();
    p3_in = 3'b100;
    step(5);
    expect_next("R8", 1'b0, 1'b0, 6'b010100);
    step();
    expect_next("R4", 1'b1, 1'b1, 6'b110100);
    step();
    p3_in = 3'b000;
    step(2);

    // R4: code 011 follows p3_in[1] only
    write_reg(6'b010011);
    do_stop(6'b110011);
    p3_in = 3'b101;
    step(15);
    expect_next("R4", 1'b0, 1'b0, 6'b110011);
    step();
    p3_in = 3'b010;
    step(5);
    expect_next("R4", 1'b0, 1'b0, 6'b110011);
    step();
    expect_next("R4", 1'b1, 1'b1, 6'b110011);
    step();
    p3_in = 3'b000;
    step(2);

    // R6: narrow NOR, an output bit drops out of the term
    write_reg(6'b010110);
    do_stop(6'b110110);
    p2_in = 8'h01; p2_dir_out = 8'h00;
    step(20);
    expect_next("R6", 1'b0, 1'b0, 6'b110110);
    step();
    p2_dir_out = 8'h01;
    step(3);
    expect_next("R6", 1'b0, 1'b0, 6'b110110);
    step();
    expect_next("R6", 1'b1, 1'b1, 6'b110110);
    step();
    p2_dir_out = 8'h00; p2_in = 8'h80;
    step(3);

    // R7/R9: low-active, narrow NOR ignores bit 7, then wide NOR with delay
    write_reg(6'b001110);
    do_stop(6'b101110);
    step(20);
    expect_next("R7", 1'b0, 1'b0, 6'b101110);
    step();
    write_reg(6'b001111);
    step(3);
    expect_next("R9", 1'b0, 1'b0, 6'b101111);
    step();
    expect_next("R9", 1'b0, 1'b1, 6'b101111);
    stop_req = 1'b1;  // R3: ignored while waiting
    step();
    stop_req = 1'b0;
    step(DLY - 2);
    expect_next("R9", 1'b0, 1'b1, 6'b101111);
    step();
    expect_next("R9", 1'b1, 1'b1, 6'b101111);
    step();

    // R4/R7: pin 7 of the eight-bit port, low level wakes
    write_reg(6'b000101);
    do_stop(6'b100101);
    step(10);
    expect_next("R7", 1'b0, 1'b0, 6'b100101);
    step();
    p2_in = 8'h00;
    step(5);
    expect_next("R7", 1'b0, 1'b0, 6'b100101);
    step();
    expect_next("R7", 1'b1, 1'b1, 6'b100101);
    step(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule